// File: doc/BRIEF.md
# Timed Interrupt-Level Override Unit

This unit sits beside instruction enqueue and produces the effective interrupt mask level that the interrupt controller compares against pending requests. A normal level-write sets the base level. An override instruction carries a packed immediate of eleven 3-bit level fields. Starting with the next enqueued instruction, each of the eleven instructions that follow runs under its own level, taken from the immediate in turn. When the last of them has been enqueued, the mask level goes back to the base level without any further instruction.

The window advances only on real enqueues, so pipeline stalls do not use it up. A flush cancels the window at once. A second override that arrives during a window reloads the fields and restarts the count. The base level that will be restored does not change when this happens. Non-maskable interrupts are always granted. A maskable request is granted only when its priority is strictly above the effective level, so level 7 blocks every maskable request.

The control is a two-state machine. IDLE means no window is open, and the effective level is the base level. WINDOW means a window is open, and the effective level is the current field. The transitions are:
- IDLE to WINDOW (open) when an override is accepted without a flush.
- WINDOW to WINDOW (reopen) when a nested override is accepted.
- WINDOW to IDLE (expire) when the eleventh field is consumed by an enqueue.
- WINDOW to IDLE (cancel) when a flush arrives.

Top module: `irq_level_window`

## Requirements
- R1: After reset the state is IDLE, `window_open` is 0 and `eff_level` is 0.
- R2: A pulse on `lvl_wr` loads `lvl_wdata` as the base level. In IDLE, `eff_level` shows the new value from the next cycle.
- R3: An accepted `ovr_valid` with no `flush` opens the window. From the next cycle `window_open` is 1 and `eff_level` equals `ovr_imm[2:0]`. Field k occupies bits [3k+2:3k].
- R4: Each `enq_valid` during a window moves `eff_level` to the next field from the next cycle. Cycles without an enqueue leave the level and the window unchanged.
- R5: The cycle after the eleventh enqueue of a window, `window_open` is 0 and `eff_level` equals the base level again.
- R6: `flush` closes the window from the next cycle and restores the base level. It takes priority over an `ovr_valid` in the same cycle.
- R7: An override during an open window reloads all eleven fields and restarts the count of eleven. The base level it will restore is unchanged.
- R8: A `lvl_wr` during a window does not change `eff_level` inside the window. It changes only the level that is restored at the end.
- R9: When `nmi_pend` is 0, `irq_grant` is 1 exactly when `irq_valid` is 1 and `irq_pri` is strictly greater than `eff_level`. Evaluation is in the same cycle.
- R10: `nmi_pend` set to 1 forces `irq_grant` to 1, including at level 7.
- R11: An `enq_valid` in the same cycle as an accepted override belongs to the override itself and does not consume a field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_wr | input | 1 | Write the base interrupt level |
| lvl_wdata | input | 3 | Base level value |
| ovr_valid | input | 1 | Override instruction accepted |
| ovr_imm | input | 33 | Eleven packed 3-bit level fields, lowest first |
| enq_valid | input | 1 | One instruction enqueued this cycle |
| flush | input | 1 | Pipeline flush |
| irq_valid | input | 1 | A maskable request is pending |
| irq_pri | input | 3 | Priority of the pending maskable request |
| nmi_pend | input | 1 | Non-maskable request pending |
| eff_level | output | 3 | Effective interrupt mask level |
| window_open | output | 1 | An override window is active |
| irq_grant | output | 1 | Pending request is accepted |

## Verification
The hardest situations to reach are the ones where events overlap inside a window. Examples are a nested override arriving partway through a window, a base-level write landing mid-window, and a flush coinciding with an override. The stimulus opens windows with irregular stall gaps between enqueues. It then injects the overlapping event at a chosen field index. After that it walks the remaining enqueues to the expiry edge, while a behavioural queue model predicts the level on every clock.

// File: rtl/irq_level_window_pkg.sv
package irq_level_window_pkg;
    typedef enum logic [0:0] {
        WIN_IDLE   = 1'b0,
        WIN_ACTIVE = 1'b1
    } win_state_t;
endpackage

// File: rtl/ovr_window_fsm.sv
module ovr_window_fsm
    import irq_level_window_pkg::*;
#(
    parameter int SLOTS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_valid,
    input  logic flush,
    input  logic enq_valid,
    output logic active,
    output logic load_en,
    output logic shift_en
);
    localparam int CNT_W = $clog2(SLOTS + 1);

    win_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State and counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        active   = 1'b0;
        load_en  = ovr_valid && !flush;
        shift_en = 1'b0;
        unique case (state_q)
            WIN_IDLE: begin
                if (load_en) begin
                    state_d = WIN_ACTIVE;
                    cnt_d   = CNT_W'(SLOTS);
                end
            end
            WIN_ACTIVE: begin
                active = 1'b1;
                if (flush) begin
                    state_d = WIN_IDLE;
                    cnt_d   = '0;
                end else if (load_en) begin
                    cnt_d = CNT_W'(SLOTS);
                end else if (enq_valid) begin
                    shift_en = 1'b1;
                    cnt_d    = cnt_q - CNT_W'(1);
                    if (cnt_q == CNT_W'(1)) begin
                        state_d = WIN_IDLE;
                    end
                end
            end
            default: state_d = WIN_IDLE;
        endcase
    end
endmodule

// File: rtl/ovr_field_shift.sv
module ovr_field_shift #(
    parameter int LVL_W = 3,
    parameter int SLOTS = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_en,
    input  logic                   shift_en,
    input  logic [LVL_W*SLOTS-1:0] imm,
    output logic [LVL_W-1:0]       head
);
    logic [LVL_W-1:0] slot_q [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [LVL_W-1:0] next_in;
        if (i == SLOTS - 1) begin : g_last
            assign next_in = '0;
        end else begin : g_mid
            assign next_in = slot_q[i+1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (load_en) begin
                slot_q[i] <= imm[i*LVL_W +: LVL_W];
            end else if (shift_en) begin
                slot_q[i] <= next_in;
            end
        end
    end

    assign head = slot_q[0];
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate #(
    parameter int LVL_W = 3
) (
    input  logic             irq_valid,
    input  logic [LVL_W-1:0] irq_pri,
    input  logic             nmi_pend,
    input  logic [LVL_W-1:0] level,
    output logic             grant
);
    always_comb begin
        grant = nmi_pend || (irq_valid && (irq_pri > level));
    end
endmodule

// File: rtl/irq_level_window.sv
module irq_level_window #(
    parameter int LVL_W = 3,
    parameter int SLOTS = 11,
    localparam int IMM_W = LVL_W * SLOTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_wr,
    input  logic [LVL_W-1:0] lvl_wdata,
    input  logic             ovr_valid,
    input  logic [IMM_W-1:0] ovr_imm,
    input  logic             enq_valid,
    input  logic             flush,
    input  logic             irq_valid,
    input  logic [LVL_W-1:0] irq_pri,
    input  logic             nmi_pend,
    output logic [LVL_W-1:0] eff_level,
    output logic             window_open,
    output logic             irq_grant
);
    logic             active, load_en, shift_en;
    logic [LVL_W-1:0] head;
    logic [LVL_W-1:0] base_q;

    // Base level kept across windows; restored when the window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (lvl_wr) begin
            base_q <= lvl_wdata;
        end
    end

    ovr_window_fsm #(.SLOTS(SLOTS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovr_valid (ovr_valid),
        .flush     (flush),
        .enq_valid (enq_valid),
        .active    (active),
        .load_en   (load_en),
        .shift_en  (shift_en)
    );

    ovr_field_shift #(.LVL_W(LVL_W), .SLOTS(SLOTS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .shift_en (shift_en),
        .imm      (ovr_imm),
        .head     (head)
    );

    always_comb begin
        eff_level   = active ? head : base_q;
        window_open = active;
    end

    irq_accept_gate #(.LVL_W(LVL_W)) u_gate (
        .irq_valid (irq_valid),
        .irq_pri   (irq_pri),
        .nmi_pend  (nmi_pend),
        .level     (eff_level),
        .grant     (irq_grant)
    );
endmodule

// File: rtl/irq_level_window_chk.sv
module irq_level_window_chk #(
    parameter int LVL_W = 3,
    parameter int SLOTS = 11
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lvl_wr,
    input logic                   ovr_valid,
    input logic [LVL_W*SLOTS-1:0] ovr_imm,
    input logic                   enq_valid,
    input logic                   flush,
    input logic                   irq_valid,
    input logic [LVL_W-1:0]       irq_pri,
    input logic                   nmi_pend,
    input logic [LVL_W-1:0]       eff_level,
    input logic                   window_open,
    input logic                   irq_grant
);
    // R3
    open_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_valid && !flush) |=> (window_open && eff_level == $past(ovr_imm[LVL_W-1:0])));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (window_open && !enq_valid && !ovr_valid && !flush) |=> (window_open && $stable(eff_level)));

    // R6
    flush_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !window_open);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!window_open && !ovr_valid && !lvl_wr) |=> (!window_open && $stable(eff_level)));

    // R9
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_pend && (!irq_valid || irq_pri <= eff_level)) |-> !irq_grant);

    // R10
    nmi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend |-> irq_grant);
endmodule

bind irq_level_window irq_level_window_chk #(.LVL_W(LVL_W), .SLOTS(SLOTS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lvl_wr      (lvl_wr),
    .ovr_valid   (ovr_valid),
    .ovr_imm     (ovr_imm),
    .enq_valid   (enq_valid),
    .flush       (flush),
    .irq_valid   (irq_valid),
    .irq_pri     (irq_pri),
    .nmi_pend    (nmi_pend),
    .eff_level   (eff_level),
    .window_open (window_open),
    .irq_grant   (irq_grant)
);

// File: tb/irq_level_window_tb_top.sv
module irq_level_window_tb_top;
    localparam int LW = 3;
    localparam int NS = 11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lvl_wr;
    logic [LW-1:0] lvl_wdata;
    logic          ovr_valid;
    logic [LW*NS-1:0] ovr_imm;
    logic          enq_valid;
    logic          flush;
    logic          irq_valid;
    logic [LW-1:0] irq_pri;
    logic          nmi_pend;
    logic [LW-1:0] eff_level;
    logic          window_open;
    logic          irq_grant;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state.
    int ref_base = 0;
    bit ref_open = 1'b0;
    int ref_q[$];

    always #2 clk = ~clk;

    irq_level_window dut_i (
        .clk(clk), .rst_n(rst_n), .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
        .ovr_valid(ovr_valid), .ovr_imm(ovr_imm), .enq_valid(enq_valid),
        .flush(flush), .irq_valid(irq_valid), .irq_pri(irq_pri),
        .nmi_pend(nmi_pend), .eff_level(eff_level),
        .window_open(window_open), .irq_grant(irq_grant)
    );

    function automatic int ref_level();
        return ref_open ? ref_q[0] : ref_base;
    endfunction

    function automatic logic [LW*NS-1:0] mk_imm(int seed);
        logic [LW*NS-1:0] v = '0;
        for (int i = 0; i < NS; i++) v[i*LW +: LW] = LW'((seed + i * 5) % 8);
        return v;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Compare outputs before the edge, then advance the model on the edge.
    task automatic step(string tag);
        int exp_g;
        #1;
        exp_g = (nmi_pend || (irq_valid && int'(irq_pri) > ref_level())) ? 1 : 0;
        check(tag, "eff_level", int'(eff_level), ref_level());
        check(tag, "window_open", int'(window_open), int'(ref_open));
        check(tag, "irq_grant", int'(irq_grant), exp_g);
        @(posedge clk);
        if (!rst_n) begin
            ref_base = 0; ref_open = 0; ref_q.delete();
        end else begin
            if (lvl_wr) ref_base = int'(lvl_wdata);
            if (flush) begin
                ref_open = 0; ref_q.delete();
            end else if (ovr_valid) begin
                ref_q.delete();
                for (int i = 0; i < NS; i++) ref_q.push_back(int'(ovr_imm[i*LW +: LW]));
                ref_open = 1;
            end else if (ref_open && enq_valid) begin
                void'(ref_q.pop_front());
                if (ref_q.size() == 0) ref_open = 0;
            end
        end
        @(negedge clk);
        lvl_wr = 0; ovr_valid = 0; enq_valid = 0; flush = 0;
    endtask

    task automatic enq_n(int n, string tag);
        for (int i = 0; i < n; i++) begin
            enq_valid = 1; step(tag);
            step(tag); // stall cycle
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; lvl_wr = 0; lvl_wdata = 0; ovr_valid = 0; ovr_imm = '0;
        enq_valid = 0; flush = 0; irq_valid = 0; irq_pri = 0; nmi_pend = 0;
        @(negedge clk);
        step("R1"); step("R1");
        rst_n = 1;
        step("R1");
        // R2 base level write
        lvl_wr = 1; lvl_wdata = 3'd2; step("R2");
        step("R2");
        // R9 compare around base level
        irq_valid = 1; irq_pri = 3'd2; step("R9");
        irq_pri = 3'd3; step("R9");
        // R3 open window, R11 enqueue in same cycle not counted
        ovr_imm = mk_imm(1); ovr_valid = 1; enq_valid = 1; step("R11");
        step("R3");
        // R4 walk fields with stalls, R9 on each
        irq_pri = 3'd4;
        enq_n(5, "R4");
        // R8 base write mid-window
        lvl_wr = 1; lvl_wdata = 3'd5; step("R8");
        enq_n(5, "R8");
        // R5 last enqueue restores base
        enq_valid = 1; step("R5");
        step("R5");
        // R6 flush mid-window
        ovr_imm = mk_imm(3); ovr_valid = 1; step("R6");
        enq_n(3, "R6");
        flush = 1; step("R6");
        step("R6");
        // R6 flush beats override
        flush = 1; ovr_valid = 1; ovr_imm = mk_imm(6); step("R6");
        step("R6");
        // R7 nested override restarts count
        ovr_imm = mk_imm(2); ovr_valid = 1; step("R7");
        enq_n(4, "R7");
        ovr_imm = mk_imm(7); ovr_valid = 1; step("R7");
        enq_n(10, "R7");
        enq_valid = 1; step("R7");
        step("R7");
        // R10 NMI at level 7
        lvl_wr = 1; lvl_wdata = 3'd7; step("R10");
        irq_pri = 3'd7; step("R10");
        nmi_pend = 1; step("R10");
        irq_valid = 0; step("R10");
        nmi_pend = 0; step("R9");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule